// File: doc/BRIEF.md
# Speculative Load Fault Tracker

This block screens one speculative load per cycle before the memory access is issued. It adds the base register value to either a displacement register value or an immediate to form the effective address. It then checks that address for alignment against the access size, and checks the destination register index for pairing or quad alignment. A detected fault never traps. Instead it marks the destination register with a deferred-fault flag. One flag vector is kept for the 64 integer registers and one for the 64 float registers. A flag that is already set on a source register is carried over to the destination, and the load is then suppressed.

When fault logging is switched on, each request claims one entry of a small record file. Each entry holds a packed status word and the effective address. Recovery logic downstream reads entries back through a one-cycle read port. The response (perform-load decision, logged, overflow, entry index) is registered and appears one cycle after the request.

Top module: `spec_load_tracker`

## Requirements
- R1: Size code 0 is a byte, 1 a halfword, 2 a word, 3 a doubleword and 4 a quadword. Codes 5 to 7 are checked like a byte. A byte never has an address fault. A halfword faults when address bit 0 is set, a word when bits [1:0] are nonzero, a doubleword when bits [2:0] are nonzero, and a quadword when bits [3:0] are nonzero.
- R2: A register fault occurs for a doubleword with an odd destination index, and for a quadword whose destination index has nonzero bits [1:0].
- R3: On an address or register fault, the destination flag is set in the float vector when `req_fp`=1 and in the integer vector otherwise. The other vector is unchanged, and `rsp_load` is 1.
- R4: With no fault, the destination flag becomes the OR of the base register flag and, when `req_use_reg`=1, the displacement register flag. Both flags are taken from the vector selected by `req_fp`. When the OR is 1 the load is suppressed (`rsp_load`=0); otherwise the flag is cleared and `rsp_load`=1.
- R5: When `req_use_reg`=0 the immediate is used, and the flag of `req_disp_idx` has no effect.
- R6: The effective address is the 32-bit wrapping sum of the base value and the selected displacement. It is stored in the address word of the allocated entry.
- R7: Logging is active only when `log_valid` and `log_enable` are both 1. Otherwise no entry is written and `rsp_logged`=`rsp_ovf`=0.
- R8: The allocated entry is the lowest index below `log_count` whose valid bit is clear. Its index is returned on `rsp_entry`.
- R9: The entry status word holds: bit 0 valid=1, bit 1 address-valid=1, bit 2 the float selector, bits [5:3] the size code, bits [11:6] the destination index, and bits [15:12] the entry's own index.
- R10: Bits [17:16] hold the register-fault cause, 1 when R2 applies and 0 otherwise. Bits [19:18] hold the address-fault cause, 2 when R1 applies and 0 otherwise.
- R11: With logging active and no free entry, `rsp_ovf`=1 and the record file is left unchanged.
- R12: Reset clears both flag vectors, all entry valid bits and all responses. The read port returns zeros for an entry that is not valid. A read of an entry in the same cycle as its allocation returns the old (zero) contents.
- R13: All responses and flag updates appear exactly one clock after the request. A request sees the flag updates of every earlier request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_fp | input | 1 | 1 selects the float flag vector |
| req_size | input | 3 | Access size code |
| req_base | input | AW | Base register value |
| req_disp | input | AW | Displacement register value |
| req_imm | input | AW | Immediate displacement |
| req_use_reg | input | 1 | 1 uses the displacement register, 0 the immediate |
| req_base_idx | input | 6 | Base register index |
| req_disp_idx | input | 6 | Displacement register index |
| req_tgt_idx | input | 6 | Destination register index |
| log_valid | input | 1 | Logging control valid |
| log_enable | input | 1 | Logging enable |
| log_count | input | CW | Number of usable entries |
| rd_idx | input | IW | Record read index |
| rsp_valid | output | 1 | Response present |
| rsp_load | output | 1 | 1 performs the load, 0 suppresses it |
| rsp_logged | output | 1 | An entry was allocated |
| rsp_ovf | output | 1 | Logging active but no entry free |
| rsp_entry | output | IW | Allocated entry index |
| gp_ne | output | 64 | Integer deferred-fault flags |
| fp_ne | output | 64 | Float deferred-fault flags |
| rd_status | output | 20 | Status word of the read entry |
| rd_addr | output | AW | Effective address of the read entry |

## Verification
Two functions can meet in one cycle. The first is a flag read and a flag write on the same register: the destination index equals the base or displacement index. Directed requests provoke this, and the bench model reads the flag before updating it. The second is an allocation of an entry while the read port addresses that same entry. The bench drives both in one cycle, expects zeros that cycle, and expects the new status and address on the next idle read. Random traffic, with indices and address bits biased toward both alignments, repeats both collisions many times. All results are judged against a bench model of the flags and the record file.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int REG_IDX_W = 6;
  localparam int NREG      = 1 << REG_IDX_W;
  localparam int REC_IDX_W = 4;

  localparam logic [2:0] SZ_BYTE = 3'd0;
  localparam logic [2:0] SZ_HALF = 3'd1;
  localparam logic [2:0] SZ_WORD = 3'd2;
  localparam logic [2:0] SZ_DBL  = 3'd3;
  localparam logic [2:0] SZ_QUAD = 3'd4;

  localparam logic [1:0] CAUSE_REG = 2'd1;
  localparam logic [1:0] CAUSE_MEM = 2'd2;

  typedef struct packed {
    logic [1:0]           mem_cause;
    logic [1:0]           reg_cause;
    logic [REC_IDX_W-1:0] idx;
    logic [REG_IDX_W-1:0] dest;
    logic [2:0]           size;
    logic                 fp;
    logic                 eav;
    logic                 vld;
  } rec_t;

  localparam int REC_W = $bits(rec_t);
endpackage

// File: rtl/slt_align_chk.sv
module slt_align_chk import slt_pkg::*; #(
  parameter int AW = 32
) (
  input  logic [2:0]           size,
  input  logic [AW-1:0]        ea,
  input  logic [REG_IDX_W-1:0] tgt,
  output logic                 mem_err,
  output logic                 reg_err
);
  always_comb begin
    mem_err = 1'b0;
    reg_err = 1'b0;
    case (size)
      SZ_HALF: mem_err = ea[0];
      SZ_WORD: mem_err = |ea[1:0];
      SZ_DBL: begin
        mem_err = |ea[2:0];
        reg_err = tgt[0];
      end
      SZ_QUAD: begin
        mem_err = |ea[3:0];
        reg_err = |tgt[1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/slt_flag_bank.sv
module slt_flag_bank import slt_pkg::*; (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_fp,
  input  logic [REG_IDX_W-1:0] base_idx,
  input  logic [REG_IDX_W-1:0] disp_idx,
  output logic                 base_ne,
  output logic                 disp_ne,
  input  logic                 upd_en,
  input  logic [REG_IDX_W-1:0] upd_idx,
  input  logic                 upd_val,
  output logic [NREG-1:0]      gp_q,
  output logic [NREG-1:0]      fp_q
);
  logic [NREG-1:0] bank_q [2];
  logic [NREG-1:0] sel_vec;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank_q[g] <= '0;
      else if (upd_en && (sel_fp == 1'(g)))
        bank_q[g][upd_idx] <= upd_val;
    end

    p_upd_lands_r3: assert property (@(posedge clk) disable iff (rst)
      (upd_en && sel_fp == 1'(g)) |=> bank_q[g][$past(upd_idx)] == $past(upd_val));

    p_other_bank_r3: assert property (@(posedge clk) disable iff (rst)
      (upd_en && sel_fp != 1'(g)) |=> $stable(bank_q[g]));
  end

  assign sel_vec = bank_q[sel_fp];
  assign base_ne = sel_vec[base_idx];
  assign disp_ne = sel_vec[disp_idx];
  assign gp_q    = bank_q[0];
  assign fp_q    = bank_q[1];
endmodule

// File: rtl/slt_rec_file.sv
module slt_rec_file import slt_pkg::*; #(
  parameter  int AW    = 32,
  parameter  int DEPTH = 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_req,
  input  logic [CW-1:0] log_count,
  input  rec_t          wr_rec,
  input  logic [AW-1:0] wr_addr,
  output logic          free_any,
  output logic [IW-1:0] pick,
  input  logic [IW-1:0] rd_idx,
  output rec_t          rd_rec,
  output logic [AW-1:0] rd_addr
);
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] free;
  rec_t             stat_mem [DEPTH];
  logic [AW-1:0]    addr_mem [DEPTH];
  rec_t             rd_raw;
  logic [AW-1:0]    rd_addr_raw;
  logic             rd_vld_q;
  logic             we;

  for (genvar i = 0; i < DEPTH; i++) begin : g_free
    assign free[i] = !valid_q[i] && (log_count > CW'(i));
  end

  always_comb begin
    pick     = '0;
    free_any = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free[i]) begin
        pick     = IW'(i);
        free_any = 1'b1;
      end
    end
  end

  assign we = alloc_req && free_any;

  always_ff @(posedge clk) begin
    if (rst)
      valid_q <= '0;
    else if (we)
      valid_q[pick] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      stat_mem[pick] <= wr_rec;
      addr_mem[pick] <= wr_addr;
    end
  end

  always_ff @(posedge clk) begin
    rd_raw      <= stat_mem[rd_idx];
    rd_addr_raw <= addr_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld_q <= 1'b0;
    else     rd_vld_q <= valid_q[rd_idx];
  end

  assign rd_rec  = rd_vld_q ? rd_raw : '0;
  assign rd_addr = rd_vld_q ? rd_addr_raw : '0;

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && !free_any) |=> $stable(valid_q));

  p_single_alloc_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(valid_q ^ $past(valid_q)));

  p_pick_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && free_any) |-> (CW'(pick) < log_count) && !valid_q[pick]);
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker import slt_pkg::*; #(
  parameter  int AW    = 32,
  parameter  int DEPTH = 8,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_fp,
  input  logic [2:0]           req_size,
  input  logic [AW-1:0]        req_base,
  input  logic [AW-1:0]        req_disp,
  input  logic [AW-1:0]        req_imm,
  input  logic                 req_use_reg,
  input  logic [REG_IDX_W-1:0] req_base_idx,
  input  logic [REG_IDX_W-1:0] req_disp_idx,
  input  logic [REG_IDX_W-1:0] req_tgt_idx,
  input  logic                 log_valid,
  input  logic                 log_enable,
  input  logic [CW-1:0]        log_count,
  input  logic [IW-1:0]        rd_idx,
  output logic                 rsp_valid,
  output logic                 rsp_load,
  output logic                 rsp_logged,
  output logic                 rsp_ovf,
  output logic [IW-1:0]        rsp_entry,
  output logic [NREG-1:0]      gp_ne,
  output logic [NREG-1:0]      fp_ne,
  output logic [REC_W-1:0]     rd_status,
  output logic [AW-1:0]        rd_addr
);
  logic [AW-1:0] ea;
  logic          mem_err, reg_err, any_err;
  logic          base_ne, disp_ne, src_ne;
  logic          log_active, alloc_req;
  logic          free_any;
  logic [IW-1:0] pick;
  rec_t          wr_rec, rd_rec;
  logic [REG_IDX_W-1:0] rsp_tgt_q;
  logic          rsp_fp_q;

  assign ea = req_base + (req_use_reg ? req_disp : req_imm);

  slt_align_chk #(.AW(AW)) u_chk (
    .size    (req_size),
    .ea      (ea),
    .tgt     (req_tgt_idx),
    .mem_err (mem_err),
    .reg_err (reg_err)
  );

  assign any_err = mem_err | reg_err;
  assign src_ne  = base_ne | (req_use_reg & disp_ne);

  slt_flag_bank u_flags (
    .clk      (clk),
    .rst      (rst),
    .sel_fp   (req_fp),
    .base_idx (req_base_idx),
    .disp_idx (req_disp_idx),
    .base_ne  (base_ne),
    .disp_ne  (disp_ne),
    .upd_en   (req_valid),
    .upd_idx  (req_tgt_idx),
    .upd_val  (any_err | src_ne),
    .gp_q     (gp_ne),
    .fp_q     (fp_ne)
  );

  assign log_active = log_valid & log_enable;
  assign alloc_req  = req_valid & log_active;

  always_comb begin
    wr_rec           = '0;
    wr_rec.vld       = 1'b1;
    wr_rec.eav       = 1'b1;
    wr_rec.fp        = req_fp;
    wr_rec.size      = req_size;
    wr_rec.dest      = req_tgt_idx;
    wr_rec.idx       = REC_IDX_W'(pick);
    wr_rec.reg_cause = reg_err ? CAUSE_REG : 2'd0;
    wr_rec.mem_cause = mem_err ? CAUSE_MEM : 2'd0;
  end

  slt_rec_file #(.AW(AW), .DEPTH(DEPTH)) u_recs (
    .clk       (clk),
    .rst       (rst),
    .alloc_req (alloc_req),
    .log_count (log_count),
    .wr_rec    (wr_rec),
    .wr_addr   (ea),
    .free_any  (free_any),
    .pick      (pick),
    .rd_idx    (rd_idx),
    .rd_rec    (rd_rec),
    .rd_addr   (rd_addr)
  );

  assign rd_status = rd_rec;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_load   <= 1'b0;
      rsp_logged <= 1'b0;
      rsp_ovf    <= 1'b0;
      rsp_entry  <= '0;
      rsp_tgt_q  <= '0;
      rsp_fp_q   <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_load   <= req_valid & (any_err | ~src_ne);
      rsp_logged <= alloc_req & free_any;
      rsp_ovf    <= alloc_req & ~free_any;
      rsp_entry  <= pick;
      rsp_tgt_q  <= req_tgt_idx;
      rsp_fp_q   <= req_fp;
    end
  end

  p_byte_clean_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == SZ_BYTE) |-> !mem_err);

  p_suppress_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_load) |-> (rsp_fp_q ? fp_ne[rsp_tgt_q] : gp_ne[rsp_tgt_q]));

  p_log_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_logged || rsp_ovf) |-> $past(log_valid && log_enable && req_valid));

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(rsp_logged && rsp_ovf));
endmodule

// File: tb/spec_load_tracker_bench.sv
module spec_load_tracker_bench;
  localparam int AW = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_fp, req_use_reg;
  logic [2:0] req_size;
  logic [31:0] req_base, req_disp, req_imm;
  logic [5:0] req_base_idx, req_disp_idx, req_tgt_idx;
  logic log_valid, log_enable;
  logic [3:0] log_count;
  logic [2:0] rd_idx;
  logic rsp_valid, rsp_load, rsp_logged, rsp_ovf;
  logic [2:0] rsp_entry;
  logic [63:0] gp_ne, fp_ne;
  logic [19:0] rd_status;
  logic [31:0] rd_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] gm, fm;
  bit          mv [DEPTH];
  logic [19:0] ms [DEPTH];
  logic [31:0] ma [DEPTH];
  int          last_entry;
  bit          last_logged;

  always #5 clk = ~clk;

  spec_load_tracker #(.AW(AW), .DEPTH(DEPTH)) u_spec_load_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_fp(req_fp),
    .req_size(req_size), .req_base(req_base), .req_disp(req_disp),
    .req_imm(req_imm), .req_use_reg(req_use_reg),
    .req_base_idx(req_base_idx), .req_disp_idx(req_disp_idx),
    .req_tgt_idx(req_tgt_idx), .log_valid(log_valid),
    .log_enable(log_enable), .log_count(log_count), .rd_idx(rd_idx),
    .rsp_valid(rsp_valid), .rsp_load(rsp_load), .rsp_logged(rsp_logged),
    .rsp_ovf(rsp_ovf), .rsp_entry(rsp_entry), .gp_ne(gp_ne),
    .fp_ne(fp_ne), .rd_status(rd_status), .rd_addr(rd_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  function automatic bit f_mem_err(input logic [2:0] sz, input logic [31:0] a);
    case (sz)
      3'd1: return a[0];
      3'd2: return |a[1:0];
      3'd3: return |a[2:0];
      3'd4: return |a[3:0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit f_reg_err(input logic [2:0] sz, input logic [5:0] t);
    if (sz == 3'd3) return t[0];
    if (sz == 3'd4) return |t[1:0];
    return 1'b0;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 0; req_fp = 0; req_use_reg = 0; req_size = 0;
    req_base = 0; req_disp = 0; req_imm = 0;
    req_base_idx = 0; req_disp_idx = 0; req_tgt_idx = 0;
    log_valid = 0; log_enable = 0; log_count = 0; rd_idx = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    gm = '0; fm = '0;
    for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; ms[i] = '0; ma[i] = '0; end
    chk("R12 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R12 gp_ne", gp_ne, 64'd0);
    chk("R12 fp_ne", fp_ne, 64'd0);
  endtask

  task automatic do_req(input string tag, input bit fp, input logic [2:0] sz,
                        input logic [31:0] b, input logic [31:0] d, input logic [31:0] im,
                        input bit use_r, input logic [5:0] bi, input logic [5:0] di,
                        input logic [5:0] ti, input bit lv, input bit le, input int lc);
    logic [31:0] ea;
    logic [63:0] vec;
    bit me, re, err, src, ld, act, found, lg, ov;
    int pk;
    ea = b + (use_r ? d : im);
    me = f_mem_err(sz, ea);
    re = f_reg_err(sz, ti);
    err = me | re;
    vec = fp ? fm : gm;
    src = vec[bi] | (use_r & vec[di]);
    ld = err | !src;
    vec[ti] = err | src;
    if (fp) fm = vec; else gm = vec;
    act = lv & le;
    found = 0; pk = 0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!mv[i] && i < lc) begin found = 1; pk = i; end
    lg = act & found;
    ov = act & !found;
    req_valid = 1; req_fp = fp; req_size = sz; req_base = b; req_disp = d;
    req_imm = im; req_use_reg = use_r; req_base_idx = bi; req_disp_idx = di;
    req_tgt_idx = ti; log_valid = lv; log_enable = le; log_count = 4'(lc);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (lg) begin
      mv[pk] = 1;
      ms[pk] = {(me ? 2'd2 : 2'd0), (re ? 2'd1 : 2'd0), 4'(pk), ti, sz, fp, 1'b1, 1'b1};
      ma[pk] = ea;
    end
    last_logged = lg; last_entry = pk;
    chk({tag, " R13 rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
    chk({tag, " R4 rsp_load"}, {63'd0, rsp_load}, {63'd0, ld});
    chk({tag, " R7 rsp_logged"}, {63'd0, rsp_logged}, {63'd0, lg});
    chk({tag, " R11 rsp_ovf"}, {63'd0, rsp_ovf}, {63'd0, ov});
    if (lg) chk({tag, " R8 rsp_entry"}, {61'd0, rsp_entry}, 64'(pk));
    chk({tag, " R3 gp_ne"}, gp_ne, gm);
    chk({tag, " R3 fp_ne"}, fp_ne, fm);
  endtask

  task automatic rd_chk(input string tag, input int idx);
    rd_idx = 3'(idx);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R9 rd_status"}, {44'd0, rd_status}, {44'd0, (mv[idx] ? ms[idx] : 20'd0)});
    chk({tag, " R6 rd_addr"}, {32'd0, rd_addr}, {32'd0, (mv[idx] ? ma[idx] : 32'd0)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog act 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    rd_chk("R12", 0);
    // R1 address alignment per size
    do_req("R1 byte odd",  0, 3'd0, 32'h1001, 0, 0, 0, 1, 0, 1, 0, 0, 0);
    do_req("R1 half odd",  0, 3'd1, 32'h1001, 0, 0, 0, 1, 0, 2, 0, 0, 0);
    do_req("R1 half ok",   0, 3'd1, 32'h1002, 0, 0, 0, 3, 0, 3, 0, 0, 0);
    do_req("R1 word 2",    0, 3'd2, 32'h1000, 0, 2, 0, 3, 0, 4, 0, 0, 0);
    do_req("R1 dbl 4",     0, 3'd3, 32'h1004, 0, 0, 0, 3, 0, 6, 0, 0, 0);
    do_req("R1 quad 8",    0, 3'd4, 32'h1000, 0, 8, 0, 3, 0, 8, 0, 0, 0);
    do_req("R1 code7",     0, 3'd7, 32'h1003, 0, 0, 0, 3, 0, 9, 0, 0, 0);
    // R2 register alignment
    do_req("R2 dbl odd",   0, 3'd3, 32'h2000, 0, 0, 0, 3, 0, 5, 0, 0, 0);
    do_req("R2 quad 2",    0, 3'd4, 32'h2000, 0, 0, 0, 3, 0, 14, 0, 0, 0);
    // R4 propagation, including target equal to source
    do_req("R4 base",      0, 3'd2, 32'h3000, 0, 0, 0, 5, 0, 10, 0, 0, 0);
    do_req("R4 same",      0, 3'd2, 32'h3000, 0, 0, 0, 10, 0, 10, 0, 0, 0);
    do_req("R4 disp",      0, 3'd2, 32'h3000, 32'h4, 0, 1, 3, 5, 11, 0, 0, 0);
    // R5 immediate ignores the displacement flag
    do_req("R5 imm",       0, 3'd2, 32'h3000, 32'h4, 0, 0, 3, 5, 11, 0, 0, 0);
    // R3 float vector only
    do_req("R3 fp err",    1, 3'd2, 32'h3001, 0, 0, 0, 3, 0, 20, 0, 0, 0);
    do_req("R3 fp prop",   1, 3'd0, 32'h3000, 0, 0, 0, 20, 0, 21, 0, 0, 0);
    // R7 logging gate
    do_req("R7 en off",    0, 3'd2, 32'h4001, 0, 0, 0, 3, 0, 30, 1, 0, 8);
    do_req("R7 vld off",   0, 3'd2, 32'h4001, 0, 0, 0, 3, 0, 30, 0, 1, 8);
    rd_chk("R7", 0);
    // R8/R10 allocation and cause codes; R12 read collision
    rd_idx = 3'd0;
    do_req("R10 mem",      0, 3'd3, 32'h5000, 0, 32'h6, 0, 3, 0, 17, 1, 1, 2);
    chk("R12 collision", {44'd0, rd_status}, 64'd0);
    rd_chk("R10", 0);
    rd_chk("R12 unused", 1);
    rd_idx = 3'd1;
    do_req("R10 reg",      1, 3'd4, 32'h5010, 0, 0, 0, 3, 0, 18, 1, 1, 2);
    chk("R12 collision", {44'd0, rd_status}, 64'd0);
    rd_chk("R10", 1);
    do_req("R11 full",     0, 3'd0, 32'h5020, 0, 0, 0, 3, 0, 19, 1, 1, 2);
    rd_chk("R11", 2);
    do_req("R8 wider",     0, 3'd0, 32'h5030, 0, 0, 0, 3, 0, 22, 1, 1, 3);
    rd_chk("R8", 2);
    do_req("R11 zero",     0, 3'd0, 32'h5040, 0, 0, 0, 3, 0, 23, 1, 1, 0);

    for (int round = 0; round < 4; round++) begin
      do_reset();
      for (int n = 0; n < 150; n++) begin
        logic [31:0] b, d, im;
        logic [5:0] ti;
        b = $urandom;
        if ($urandom % 2 == 0) b[3:0] = 4'h0;
        d = ($urandom % 2 == 0) ? ($urandom & 32'hF0) : ($urandom & 32'hFF);
        im = ($urandom % 2 == 0) ? ($urandom & 32'hF0) : ($urandom & 32'hFF);
        ti = 6'($urandom);
        if ($urandom % 2 == 0) ti[1:0] = 2'b00;
        rd_idx = 3'($urandom);
        do_req("RND", 1'($urandom), 3'($urandom % 6), b, d, im, 1'($urandom),
               6'($urandom % 16), 6'($urandom % 16), ti,
               ($urandom % 4) != 0, ($urandom % 2) == 0, int'($urandom % 9));
        if (last_logged) rd_chk("RND", last_entry);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule